// File: doc/BRIEF.md
# Microprogram Sequencer Next-Address Unit

This block produces the address of the next microinstruction for a microcoded control unit whose control store is 512 words deep. Every microinstruction names its successor explicitly, so the unit never counts upward. Instead, it takes the stored successor address and modifies it by bitwise OR. A conditional branch ORs a selected ALU flag into the most significant address bit. An opcode dispatch ORs the fetched instruction byte into the low eight bits. A single microinstruction can therefore jump to the handler for any opcode.

The unit works as a two-register pipeline. At a rising edge it captures the microinstruction's successor address and 3-bit jump-control field, together with the negative and zero flags produced by that microinstruction's ALU operation. It then forms the next address from those held values and the instruction byte present at the following edge, and loads the result into the microprogram counter register. A conditional pair of targets always sits exactly 256 words apart: the two targets share their low eight bits and differ only in the top bit.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low at a rising edge, `mpc` becomes 0 and the held fields and flags are cleared. The first `mpc` value loaded after reset is released is therefore also 0.
- R2: With jump code 000, `mpc` equals the successor address presented two edges earlier, whatever the flags and the instruction byte hold.
- R3: With jump code 001 (bit 0 = zero-test), `mpc` bit 8 is the address bit 8 ORed with the zero flag, and bits 7..0 are copied from the address.
- R4: With jump code 010 (bit 1 = negative-test), `mpc` bit 8 is the address bit 8 ORed with the negative flag, and bits 7..0 are copied from the address.
- R5: With jump code 011, `mpc` bit 8 is the address bit 8 ORed with (zero OR negative).
- R6: With jump code 100 (bit 2 = dispatch), `mpc` bits 7..0 are the address bits 7..0 ORed with `mbr`, and bit 8 is copied from the address.
- R7: Jump codes 101, 110 and 111 apply the dispatch OR to the low byte and the flag OR of R3 to R5 to bit 8 together.
- R8: For one successor address with bit 8 clear and a conditional jump code, the taken and not-taken results differ by exactly 256 and share bits 7..0.
- R9: The flags used are the ones presented in the same cycle as the address and jump code. Flag values presented one cycle later have no effect on that result.
- R10: `mbr` is sampled at the edge that loads `mpc`, which is one edge after the address, jump code and flags were captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 9 | Successor address field of the current microinstruction |
| jam | input | 3 | Jump control: bit 2 dispatch, bit 1 negative-test, bit 0 zero-test |
| n | input | 1 | Negative flag from the current ALU result |
| z | input | 1 | Zero flag from the current ALU result |
| mbr | input | 8 | Fetched instruction byte |
| mpc | output | 9 | Registered microprogram counter |

## Verification
The hardest case to reach from the ports is the one where the two pipeline stages see different inputs. The flags must come from the earlier cycle while the instruction byte comes from the later one. A test that holds every input steady for two edges cannot tell a correct design from one that takes both from the same cycle. Directed tests therefore change the flags, and separately the instruction byte, between the capture edge and the load edge, then check that only the byte change shows up in `mpc`. The table of vectors covers all eight jump codes, including both flag tests together and dispatch with a nonzero low byte in the successor address.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the microprogram next-address unit.
// Assumes the jump-control field is three bits wide, dispatch in bit 2.
package useq_pkg;

    localparam int JAM_W = 3;

    // Jump-control field; bit order matters: dispatch, negative test, zero test.
    typedef struct packed {
        logic dispatch;
        logic neg_test;
        logic zero_test;
    } jam_t;

endpackage

// File: rtl/useq_fld_stage.sv
`timescale 1ns/1ps
// Module: useq_fld_stage
// Captures the successor address, jump-control field and ALU flags of the
// microinstruction executing in this cycle. The captured flags are used
// for the next-address calculation performed during the following cycle.
// Assumes a synchronous active-low reset that clears every captured value.
module useq_fld_stage
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  jam_t              jam_i,
    input  logic              n_i,
    input  logic              z_i,
    output logic [ADDR_W-1:0] addr_q,
    output jam_t              jam_q,
    output logic              n_q,
    output logic              z_q
);

    // Hold the next-address fields of the current microinstruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            jam_q  <= '0;
        end else begin
            addr_q <= addr_i;
            jam_q  <= jam_i;
        end
    end

    // Latch the ALU flags at the end of the cycle that produced them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            n_q <= n_i;
            z_q <= z_i;
        end
    end

endmodule

// File: rtl/useq_addr_mux.sv
`timescale 1ns/1ps
// Module: useq_addr_mux
// Combinational next-address former. The top bit is ORed with the
// selected flag test; the low MBR_W bits are ORed with the instruction
// byte on dispatch; any bits in between pass straight through.
// Assumes MBR_W is smaller than ADDR_W so the top bit never overlaps
// the dispatch byte.
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int MBR_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  jam_t              jam_q,
    input  logic              n_q,
    input  logic              z_q,
    input  logic [MBR_W-1:0]  mbr_i,
    output logic [ADDR_W-1:0] nxt_o
);

    localparam int HI = ADDR_W - 1;

    logic take_hi;

    // Decide whether a flag test forces the top address bit.
    always_comb begin
        take_hi = (jam_q.zero_test & z_q) | (jam_q.neg_test & n_q);
    end

    // Per-bit OR network; the bit position picks the source.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == HI) begin : g_top
            assign nxt_o[i] = addr_q[i] | take_hi;
        end else if (i < MBR_W) begin : g_low
            assign nxt_o[i] = addr_q[i] | (jam_q.dispatch & mbr_i[i]);
        end else begin : g_mid
            assign nxt_o[i] = addr_q[i];
        end
    end

endmodule

// File: rtl/useq_mpc_reg.sv
`timescale 1ns/1ps
// Module: useq_mpc_reg
// Microprogram counter register. Loads the formed next address each cycle.
// Assumes the control store is read from this register's output.
module useq_mpc_reg #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] nxt_i,
    output logic [ADDR_W-1:0] mpc_o
);

    // Load the next microinstruction address, or zero under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mpc_o <= '0;
        else        mpc_o <= nxt_i;
    end

endmodule

// File: rtl/useq_next_addr.sv
`timescale 1ns/1ps
// Module: useq_next_addr (top)
// Next-address unit for a microprogrammed control unit. Fields and flags
// are captured at one edge; the counter loads the formed address at the
// next edge, sampling the instruction byte there.
// Assumes jam bit 2 = dispatch, bit 1 = negative test, bit 0 = zero test.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int MBR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [JAM_W-1:0]  jam,
    input  logic              n,
    input  logic              z,
    input  logic [MBR_W-1:0]  mbr,
    output logic [ADDR_W-1:0] mpc
);

    logic [ADDR_W-1:0] addr_q;
    jam_t              jam_q;
    jam_t              jam_in;
    logic              n_q;
    logic              z_q;
    logic [ADDR_W-1:0] nxt;

    // Present the raw jump field as the typed struct.
    always_comb begin
        jam_in = jam_t'(jam);
    end

    useq_fld_stage #(.ADDR_W(ADDR_W)) u_fld (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr),
        .jam_i  (jam_in),
        .n_i    (n),
        .z_i    (z),
        .addr_q (addr_q),
        .jam_q  (jam_q),
        .n_q    (n_q),
        .z_q    (z_q)
    );

    useq_addr_mux #(.ADDR_W(ADDR_W), .MBR_W(MBR_W)) u_mux (
        .addr_q (addr_q),
        .jam_q  (jam_q),
        .n_q    (n_q),
        .z_q    (z_q),
        .mbr_i  (mbr),
        .nxt_o  (nxt)
    );

    useq_mpc_reg #(.ADDR_W(ADDR_W)) u_mpc (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_i (nxt),
        .mpc_o (mpc)
    );

endmodule

// File: rtl/useq_next_addr_chk.sv
`timescale 1ns/1ps
// Module: useq_next_addr_chk
// Property checker bound to useq_next_addr. It relates mpc to the port
// values two edges (fields, flags) and one edge (instruction byte) earlier.
// Assumes the reset is synchronous and active low.
module useq_next_addr_chk #(
    parameter int ADDR_W = 9,
    parameter int MBR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        jam,
    input logic              n,
    input logic              z,
    input logic [MBR_W-1:0]  mbr,
    input logic [ADDR_W-1:0] mpc
);

    localparam int HI = ADDR_W - 1;

    logic [1:0] warm;

    // Count rising edges out of reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)           warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (mpc == '0)); // R1

    AST_PLAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !$past(jam[2], 2))
        |-> (mpc[MBR_W-1:0] == $past(addr[MBR_W-1:0], 2))); // R2

    AST_FLAG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2)
        |-> (mpc[HI] == ($past(addr[HI], 2)
                        | ($past(jam[0], 2) & $past(z, 2))
                        | ($past(jam[1], 2) & $past(n, 2))))); // R5

    AST_DISPATCH_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(jam[2], 2))
        |-> (mpc[MBR_W-1:0] == ($past(addr[MBR_W-1:0], 2) | $past(mbr, 1)))); // R6

    AST_NO_TEST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(jam[1:0], 2) == 2'b00)
        |-> (mpc[HI] == $past(addr[HI], 2))); // R8

endmodule

bind useq_next_addr useq_next_addr_chk #(.ADDR_W(ADDR_W), .MBR_W(MBR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .jam   (jam),
    .n     (n),
    .z     (z),
    .mbr   (mbr),
    .mpc   (mpc)
);

// File: tb/tb_useq_next_addr.sv
`timescale 1ns/1ps
// Bench for useq_next_addr: a vector table walked by one loop, then
// directed tests for reset, branch spacing and stage timing.
module tb_useq_next_addr;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] addr;
    logic [2:0] jam;
    logic       n;
    logic       z;
    logic [7:0] mbr;
    logic [8:0] mpc;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [3:0] req;
        logic [8:0] a;
        logic [2:0] j;
        logic       nf;
        logic       zf;
        logic [7:0] b;
        logic [8:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 9'h0A5, 3'b000, 1'b1, 1'b1, 8'hFF, 9'h0A5}, // R2
        '{4'd2, 9'h1C3, 3'b000, 1'b0, 1'b0, 8'h00, 9'h1C3}, // R2
        '{4'd3, 9'h012, 3'b001, 1'b0, 1'b1, 8'h3C, 9'h112}, // R3
        '{4'd3, 9'h012, 3'b001, 1'b1, 1'b0, 8'h3C, 9'h012}, // R3
        '{4'd3, 9'h100, 3'b001, 1'b0, 1'b1, 8'h00, 9'h100}, // R3
        '{4'd4, 9'h040, 3'b010, 1'b1, 1'b0, 8'h77, 9'h140}, // R4
        '{4'd4, 9'h040, 3'b010, 1'b0, 1'b1, 8'h77, 9'h040}, // R4
        '{4'd5, 9'h07F, 3'b011, 1'b0, 1'b1, 8'h00, 9'h17F}, // R5
        '{4'd5, 9'h07F, 3'b011, 1'b1, 1'b0, 8'h00, 9'h17F}, // R5
        '{4'd5, 9'h07F, 3'b011, 1'b0, 1'b0, 8'h00, 9'h07F}, // R5
        '{4'd6, 9'h000, 3'b100, 1'b1, 1'b1, 8'h36, 9'h036}, // R6
        '{4'd6, 9'h100, 3'b100, 1'b0, 1'b0, 8'h59, 9'h159}, // R6
        '{4'd6, 9'h0F0, 3'b100, 1'b0, 1'b0, 8'h0F, 9'h0FF}, // R6
        '{4'd7, 9'h081, 3'b101, 1'b0, 1'b1, 8'h60, 9'h1E1}, // R7
        '{4'd7, 9'h003, 3'b110, 1'b0, 1'b1, 8'h84, 9'h087}, // R7
        '{4'd7, 9'h000, 3'b111, 1'b1, 1'b0, 8'hAA, 9'h1AA}  // R7
    };

    useq_next_addr dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .jam   (jam),
        .n     (n),
        .z     (z),
        .mbr   (mbr),
        .mpc   (mpc)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: mpc=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] a, input logic [2:0] j,
                         input logic nf, input logic zf, input logic [7:0] b);
        addr = a; jam = j; n = nf; z = zf; mbr = b;
    endtask

    // Present one vector, let both stages run, sample at the falling edge.
    task automatic run_vec(input logic [8:0] a, input logic [2:0] j,
                           input logic nf, input logic zf, input logic [7:0] b,
                           output logic [8:0] res);
        @(negedge clk);
        drive(a, j, nf, zf, b);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        res = mpc;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] r0;
        logic [8:0] r1;
        rst_n = 1'b0;
        drive(9'h1FF, 3'b111, 1'b1, 1'b1, 8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset value", mpc, 9'h000);

        // First load after release comes from the cleared held fields.
        drive(9'h0A0, 3'b000, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 first load after release", mpc, 9'h000);
        @(posedge clk);
        @(negedge clk);
        check("R2 first real address", mpc, 9'h0A0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i].a, VEC[i].j, VEC[i].nf, VEC[i].zf, VEC[i].b, r0);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), r0, VEC[i].exp);
        end

        // R8: a conditional pair sits 256 apart with equal low bytes.
        run_vec(9'h055, 3'b010, 1'b0, 1'b0, 8'h00, r0);
        run_vec(9'h055, 3'b010, 1'b1, 1'b0, 8'h00, r1);
        check("R8 not-taken target", r0, 9'h055);
        check("R8 taken minus not-taken", r1 - r0, 9'h100);

        // R9: flags changed after the capture edge do not matter.
        @(negedge clk);
        drive(9'h020, 3'b001, 1'b0, 1'b1, 8'h00);
        @(posedge clk);
        @(negedge clk);
        n = 1'b1; z = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 late flags ignored", mpc, 9'h120);

        // R10: the byte is taken at the loading edge, not the capture edge.
        @(negedge clk);
        drive(9'h000, 3'b100, 1'b0, 1'b0, 8'h11);
        @(posedge clk);
        @(negedge clk);
        mbr = 8'h22;
        @(posedge clk);
        @(negedge clk);
        check("R10 byte sampled at load edge", mpc, 9'h022);

        // R1: reset in mid-run clears the counter again.
        @(negedge clk);
        drive(9'h1EE, 3'b111, 1'b1, 1'b1, 8'h11);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-run", mpc, 9'h000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 cleared fields after mid-run reset", mpc, 9'h000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule